// File: doc/BRIEF.md
# Debug Event Dispatcher

This block sits next to a small processor core and decides what a debug event turns into. A debug event can be a hardware breakpoint hit, a software breakpoint or the end of a single step. The outcome depends on four mode enables held in a small control register and on the core's machine-state debug-enable bit. The event can raise a debug interrupt for monitor software, freeze instruction issue so a JTAG debugger can take over, or produce a trace trigger pulse for an external trace capture unit.

While the block is frozen, a JTAG debugger can resume execution, release a single instruction, or request a stop. In debug-wait mode the stopped core still services external interrupts: the block acknowledges the request, lets the handler run, and stops again when the handler returns. A two-bit status field records why the last stop happened, and reading it clears it. A separate combinational output tells the core to skip the privileged-instruction check for instructions injected over JTAG while the core is in user mode.

Top module: `dbg_dispatch`

## Requirements
- R1: Control register at address 0 holds bit 0 internal-mode enable, bit 1 external-mode enable, bit 2 debug-wait enable and bit 3 trace enable. It resets to 0, a write takes effect from the next cycle, and reading address 0 returns the bits in those positions with upper bits zero.
- R2: While running with neither external nor debug-wait enabled, a debug event raises `dbg_irq` for exactly the cycle after the event, and only when the internal enable and `msr_de` are both 1.
- R3: While running with external or debug-wait enabled, a debug event sets `frozen` from the next cycle and records stop cause 1 (event).
- R4: A JTAG stop request while running freezes the core from the next cycle with stop cause 3 (external stop) when external or debug-wait is enabled, and is ignored otherwise.
- R5: When an event freezes the core and the internal enable and `msr_de` are also 1, no interrupt is raised at the event. The interrupt is held pending and `dbg_irq` pulses in the cycle after the run command, but only if the internal enable and `msr_de` are still both 1 at that point. The run command discards the pending request in either case.
- R6: A step command while frozen drops `frozen` and raises `step_grant` for exactly one cycle. In the next cycle `frozen` returns and the stop cause is 2 (step).
- R7: A run command while frozen clears `frozen` from the next cycle. A run command takes priority over a step command given in the same cycle.
- R8: In debug-wait mode, while frozen, `ext_irq` raises `irq_ack` for one cycle and clears `frozen` while the handler runs. `irq_ret` then restores `frozen` from the next cycle.
- R9: `trace_trig` pulses in the cycle after a debug event only when the control register reads exactly 4'b1000 (trace on, every stop-type mode off).
- R10: `priv_suppress` equals `jtag_insn & insn_priv & user_mode` combinationally.
- R11: Status at address 1 returns the stop cause in bits 1:0 (0 none, 1 event, 2 step, 3 external stop). A read of address 1 clears it, but a cause recorded in the same cycle wins over the clear.
- R12: Debug events that arrive while frozen or stepping raise no interrupt, cause no state change and do not alter the recorded cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clears status) |
| reg_addr | input | ADDR_W | Register address (0 control, 1 status) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from address |
| msr_de | input | 1 | Machine-state debug-enable bit |
| dbg_evt | input | 1 | Debug event strobe |
| jtag_run | input | 1 | JTAG resume command |
| jtag_stop | input | 1 | JTAG stop request |
| jtag_step | input | 1 | JTAG single-step command |
| jtag_insn | input | 1 | Current instruction was injected over JTAG |
| insn_priv | input | 1 | Current instruction is privileged |
| user_mode | input | 1 | Core is in user mode |
| ext_irq | input | 1 | External interrupt request |
| irq_ret | input | 1 | Handler return-from-interrupt |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| frozen | output | 1 | Instruction issue stopped |
| step_grant | output | 1 | One-instruction release slot |
| irq_ack | output | 1 | External interrupt acknowledged while stopped |
| trace_trig | output | 1 | Trace trigger pulse |
| priv_suppress | output | 1 | Suppress privileged-instruction exception |

## Verification
Every registered result (`dbg_irq`, `frozen`, `step_grant`, `irq_ack`, `trace_trig` and the stop cause) is due one clock after the input that causes it. The bench drives its inputs, advances its behavioural model across one rising edge, and compares every registered output 2 ns after that edge, so each result is checked in the cycle where it first becomes due. The combinational results `priv_suppress` and `reg_rdata` are checked 1 ns after their inputs change, before the next edge. The stop cause is read back through address 1 to cover both the read-clear behaviour and the case where a new cause is recorded in the same cycle as a read.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_STEP = 2'd2,
      ST_ISR  = 2'd3
   } dbg_state_t;

   typedef enum logic [1:0] {
      CZ_NONE  = 2'd0,
      CZ_EVENT = 2'd1,
      CZ_STEP  = 2'd2,
      CZ_XSTOP = 2'd3
   } stop_cause_t;

   typedef struct packed {
      logic trace_en;
      logic wait_en;
      logic ext_en;
      logic int_en;
   } dbg_ctrl_t;

   localparam int CTRL_BITS  = 4;
   localparam int CAUSE_BITS = 2;

endpackage

// File: rtl/dbg_csr.sv
module dbg_csr
   import dbg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              cause_set,
   input  stop_cause_t       cause_val,
   output dbg_ctrl_t         ctrl,
   output stop_cause_t       cause
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

   if (DATA_W > CTRL_BITS) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^reg_wdata[DATA_W-1:CTRL_BITS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (reg_wr && reg_addr == A_CTRL) begin
         ctrl <= dbg_ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= CZ_NONE;
      end else if (cause_set) begin
         cause <= cause_val;
      end else if (reg_rd && reg_addr == A_STAT) begin
         cause <= CZ_NONE;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_CTRL) begin
         reg_rdata[CTRL_BITS-1:0] = ctrl;
      end else if (reg_addr == A_STAT) begin
         reg_rdata[CAUSE_BITS-1:0] = cause;
      end
   end

endmodule

// File: rtl/dbg_stop_fsm.sv
module dbg_stop_fsm
   import dbg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  dbg_ctrl_t   ctrl,
   input  logic        dbg_evt,
   input  logic        jtag_run,
   input  logic        jtag_stop,
   input  logic        jtag_step,
   input  logic        ext_irq,
   input  logic        irq_ret,
   output dbg_state_t  st,
   output logic        frozen,
   output logic        step_grant,
   output logic        irq_ack,
   output logic        run_release,
   output logic        cause_set,
   output stop_cause_t cause_val
);

   dbg_state_t st_d;
   logic       ack_d;
   logic       stop_mode;

   assign stop_mode = ctrl.ext_en | ctrl.wait_en;

   always_comb begin
      st_d        = st;
      ack_d       = 1'b0;
      run_release = 1'b0;
      cause_set   = 1'b0;
      cause_val   = CZ_NONE;
      unique case (st)
         ST_RUN: begin
            if (dbg_evt && stop_mode) begin
               st_d      = ST_HALT;
               cause_set = 1'b1;
               cause_val = CZ_EVENT;
            end else if (jtag_stop && stop_mode) begin
               st_d      = ST_HALT;
               cause_set = 1'b1;
               cause_val = CZ_XSTOP;
            end
         end
         ST_HALT: begin
            if (jtag_run) begin
               st_d        = ST_RUN;
               run_release = 1'b1;
            end else if (jtag_step) begin
               st_d = ST_STEP;
            end else if (ctrl.wait_en && ext_irq) begin
               st_d  = ST_ISR;
               ack_d = 1'b1;
            end
         end
         ST_STEP: begin
            st_d      = ST_HALT;
            cause_set = 1'b1;
            cause_val = CZ_STEP;
         end
         ST_ISR: begin
            if (irq_ret) begin
               st_d = ST_HALT;
            end
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_RUN;
         irq_ack <= 1'b0;
      end else begin
         st      <= st_d;
         irq_ack <= ack_d;
      end
   end

   assign frozen     = (st == ST_HALT);
   assign step_grant = (st == ST_STEP);

endmodule

// File: rtl/dbg_event_route.sv
module dbg_event_route
   import dbg_pkg::*;
#(
   parameter bit TRACE_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  dbg_ctrl_t  ctrl,
   input  logic       msr_de,
   input  logic       dbg_evt,
   input  dbg_state_t st,
   input  logic       run_release,
   input  logic       jtag_insn,
   input  logic       insn_priv,
   input  logic       user_mode,
   output logic       dbg_irq,
   output logic       trace_trig,
   output logic       priv_suppress
);

   logic int_ok;
   logic stop_mode;
   logic in_run;
   logic pend_q;
   logic irq_d;
   logic trig_raw;

   assign int_ok    = ctrl.int_en & msr_de;
   assign stop_mode = ctrl.ext_en | ctrl.wait_en;
   assign in_run    = (st == ST_RUN);

   assign irq_d = (dbg_evt & in_run & ~stop_mode & int_ok)
                | (run_release & pend_q & int_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         dbg_irq <= 1'b0;
      end else begin
         dbg_irq <= irq_d;
         if (run_release) begin
            pend_q <= 1'b0;
         end else if (dbg_evt && in_run && stop_mode && int_ok) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign trig_raw = dbg_evt & ctrl.trace_en & ~ctrl.int_en
                   & ~ctrl.ext_en & ~ctrl.wait_en;

   if (TRACE_REG) begin : g_trig_ff
      logic trig_q;
      always_ff @(posedge clk) begin
         if (!rst_n) trig_q <= 1'b0;
         else        trig_q <= trig_raw;
      end
      assign trace_trig = trig_q;
   end else begin : g_trig_comb
      assign trace_trig = trig_raw;
   end

   assign priv_suppress = jtag_insn & insn_priv & user_mode;

endmodule

// File: rtl/dbg_dispatch.sv
module dbg_dispatch
   import dbg_pkg::*;
#(
   parameter int DATA_W           = 8,
   parameter int ADDR_W           = 2,
   parameter bit TRACE_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              msr_de,
   input  logic              dbg_evt,
   input  logic              jtag_run,
   input  logic              jtag_stop,
   input  logic              jtag_step,
   input  logic              jtag_insn,
   input  logic              insn_priv,
   input  logic              user_mode,
   input  logic              ext_irq,
   input  logic              irq_ret,
   output logic              dbg_irq,
   output logic              frozen,
   output logic              step_grant,
   output logic              irq_ack,
   output logic              trace_trig,
   output logic              priv_suppress
);

   if (DATA_W < CTRL_BITS) begin : g_bad_data_w
      $error("dbg_dispatch: DATA_W must be at least %0d", CTRL_BITS);
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("dbg_dispatch: ADDR_W must be at least 1");
   end

   dbg_ctrl_t   ctrl_q;
   stop_cause_t cause_q;
   dbg_state_t  st_q;
   logic        run_release;
   logic        cause_set;
   stop_cause_t cause_val;

   dbg_csr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cause_set (cause_set),
      .cause_val (cause_val),
      .ctrl      (ctrl_q),
      .cause     (cause_q)
   );

   dbg_stop_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl        (ctrl_q),
      .dbg_evt     (dbg_evt),
      .jtag_run    (jtag_run),
      .jtag_stop   (jtag_stop),
      .jtag_step   (jtag_step),
      .ext_irq     (ext_irq),
      .irq_ret     (irq_ret),
      .st          (st_q),
      .frozen      (frozen),
      .step_grant  (step_grant),
      .irq_ack     (irq_ack),
      .run_release (run_release),
      .cause_set   (cause_set),
      .cause_val   (cause_val)
   );

   dbg_event_route #(.TRACE_REG(TRACE_REGISTERED)) u_route (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctrl          (ctrl_q),
      .msr_de        (msr_de),
      .dbg_evt       (dbg_evt),
      .st            (st_q),
      .run_release   (run_release),
      .jtag_insn     (jtag_insn),
      .insn_priv     (insn_priv),
      .user_mode     (user_mode),
      .dbg_irq       (dbg_irq),
      .trace_trig    (trace_trig),
      .priv_suppress (priv_suppress)
   );

endmodule

// File: rtl/dbg_dispatch_chk.sv
module dbg_dispatch_chk #(
   parameter bit TRACE_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       dbg_evt,
   input logic       msr_de,
   input logic       jtag_run,
   input logic       jtag_step,
   input logic       ext_irq,
   input logic       dbg_irq,
   input logic       frozen,
   input logic       step_grant,
   input logic       irq_ack,
   input logic       trace_trig,
   input logic [3:0] ctrl_bits,
   input logic [1:0] cause_bits,
   input logic [1:0] st_bits
);

   // R2 / R5: an interrupt only follows a cycle with internal enable and msr_de set
   assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_irq |-> $past(ctrl_bits[0] && msr_de));

   // R3: event in run with a stop-type mode freezes the next cycle with cause 1
   assert_event_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_bits == 2'd0 && dbg_evt && (ctrl_bits[1] || ctrl_bits[2]))
      |=> (frozen && cause_bits == 2'd1));

   // R6: a step while frozen opens a single release slot
   assert_step_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && jtag_step && !jtag_run) |=> (step_grant && !frozen));

   // R6: after the release slot the block is frozen again with cause 2
   assert_step_refreeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step_grant |=> (frozen && cause_bits == 2'd2));

   // R7: run while frozen leaves the frozen state
   assert_run_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && jtag_run) |=> (!frozen && !step_grant));

   // R8: acknowledge only out of a frozen cycle with an interrupt request
   assert_wait_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (!frozen && $past(frozen && ext_irq && ctrl_bits[2])));

   // R9: trace trigger only when trace is the sole enabled mode
   assert_trace_gate_R9: assert property (@(posedge clk) disable iff (!rst_n || !TRACE_REG)
      trace_trig |-> $past(ctrl_bits == 4'b1000 && dbg_evt));

   // R6: frozen and the release slot never overlap
   assert_slot_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frozen, step_grant, irq_ack}));

endmodule

bind dbg_dispatch dbg_dispatch_chk #(.TRACE_REG(TRACE_REGISTERED)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dbg_evt    (dbg_evt),
   .msr_de     (msr_de),
   .jtag_run   (jtag_run),
   .jtag_step  (jtag_step),
   .ext_irq    (ext_irq),
   .dbg_irq    (dbg_irq),
   .frozen     (frozen),
   .step_grant (step_grant),
   .irq_ack    (irq_ack),
   .trace_trig (trace_trig),
   .ctrl_bits  (ctrl_q),
   .cause_bits (cause_q),
   .st_bits    (st_q)
);

// File: tb/dbg_dispatch_bench.sv
module dbg_dispatch_bench;

   localparam int DW = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          msr_de = 1'b0, dbg_evt = 1'b0;
   logic          jtag_run = 1'b0, jtag_stop = 1'b0, jtag_step = 1'b0;
   logic          jtag_insn = 1'b0, insn_priv = 1'b0, user_mode = 1'b0;
   logic          ext_irq = 1'b0, irq_ret = 1'b0;
   logic          dbg_irq, frozen, step_grant, irq_ack, trace_trig, priv_suppress;

   always #4 clk = ~clk;

   dbg_dispatch u_dbg_dispatch (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .msr_de(msr_de), .dbg_evt(dbg_evt), .jtag_run(jtag_run),
      .jtag_stop(jtag_stop), .jtag_step(jtag_step), .jtag_insn(jtag_insn),
      .insn_priv(insn_priv), .user_mode(user_mode), .ext_irq(ext_irq),
      .irq_ret(irq_ret), .dbg_irq(dbg_irq), .frozen(frozen),
      .step_grant(step_grant), .irq_ack(irq_ack), .trace_trig(trace_trig),
      .priv_suppress(priv_suppress)
   );

   int n_chk = 0;
   int n_err = 0;

   // behavioural model: 0 running, 1 stopped, 2 one-instruction slot, 3 in handler
   int       m_mode = 0;
   bit       m_pend = 0;
   int       m_cause = 0;
   bit [3:0] m_ctrl = '0;
   bit       e_irq = 0, e_trig = 0, e_ack = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      int  nm = m_mode;
      bit  np = m_pend;
      int  nc = m_cause;
      bit  ni = 0, nt = 0, na = 0;
      bit  can_int = m_ctrl[0] && msr_de;
      bit  stops   = m_ctrl[1] || m_ctrl[2];
      if (reg_rd && reg_addr == 1) nc = 0;
      if (m_mode == 0) begin
         if (dbg_evt && stops) begin
            nm = 1; nc = 1;
            if (can_int) np = 1;
         end else if (jtag_stop && stops) begin
            nm = 1; nc = 3;
         end else if (dbg_evt && can_int) begin
            ni = 1;
         end
      end else if (m_mode == 1) begin
         if (jtag_run) begin
            nm = 0;
            ni = m_pend && can_int;
            np = 0;
         end else if (jtag_step) begin
            nm = 2;
         end else if (m_ctrl[2] && ext_irq) begin
            nm = 3; na = 1;
         end
      end else if (m_mode == 2) begin
         nm = 1; nc = 2;
      end else begin
         if (irq_ret) nm = 1;
      end
      nt = dbg_evt && (m_ctrl == 4'b1000);
      @(posedge clk);
      if (reg_wr && reg_addr == 0) m_ctrl = reg_wdata[3:0];
      m_mode = nm; m_pend = np; m_cause = nc;
      e_irq = ni; e_trig = nt; e_ack = na;
      #2;
      chk(frozen == (m_mode == 1), "R3", "frozen", int'(frozen), int'(m_mode == 1));
      chk(step_grant == (m_mode == 2), "R6", "step_grant", int'(step_grant), int'(m_mode == 2));
      chk(dbg_irq == e_irq, "R2", "dbg_irq", int'(dbg_irq), int'(e_irq));
      chk(trace_trig == e_trig, "R9", "trace_trig", int'(trace_trig), int'(e_trig));
      chk(irq_ack == e_ack, "R8", "irq_ack", int'(irq_ack), int'(e_ack));
   endtask

   task automatic wr_ctrl(input bit [3:0] v);
      reg_addr = 0; reg_wdata = {4'hA, v}; reg_wr = 1;
      tick();
      reg_wr = 0;
   endtask

   task automatic rd(input int a, input string req);
      int expv;
      reg_addr = AW'(a); reg_rd = 1;
      #1;
      expv = (a == 0) ? int'(m_ctrl) : m_cause;
      chk(reg_rdata == DW'(expv), req, "reg_rdata", int'(reg_rdata), expv);
      tick();
      reg_rd = 0;
   endtask

   task automatic ev();  dbg_evt = 1;   tick(); dbg_evt = 0;   endtask
   task automatic run(); jtag_run = 1;  tick(); jtag_run = 0;  endtask
   task automatic stp(); jtag_step = 1; tick(); jtag_step = 0; endtask
   task automatic hlt(); jtag_stop = 1; tick(); jtag_stop = 0; endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      chk(frozen == 0 && dbg_irq == 0 && trace_trig == 0, "R1", "reset outputs",
          int'({frozen, dbg_irq, trace_trig}), 0);
      rd(0, "R1");
      rd(1, "R11");

      // trace only
      wr_ctrl(4'b1000); rd(0, "R1"); ev(); tick();
      // internal + trace: interrupt, no trigger (R2, R9)
      msr_de = 1; wr_ctrl(4'b1001); ev(); tick();
      msr_de = 0; ev(); msr_de = 1;
      // stop request without stop mode is ignored (R4)
      wr_ctrl(4'b0000); hlt(); tick();
      // external mode: event freeze, read-clear (R3, R11)
      wr_ctrl(4'b0010); ev(); rd(1, "R11"); rd(1, "R11");
      ev(); ev(); rd(1, "R12");   // events while frozen ignored
      stp(); tick(); rd(1, "R6");
      jtag_step = 1; run(); jtag_step = 0; tick();   // R7 run wins
      // both internal and external: pending interrupt on run (R5)
      wr_ctrl(4'b0011); ev(); tick(); tick(); run(); tick();
      ev(); msr_de = 0; run(); tick(); msr_de = 1;
      // external stop request (R4)
      wr_ctrl(4'b0010); hlt(); rd(1, "R4"); run();
      // debug-wait: stop, service interrupt, return (R8)
      wr_ctrl(4'b0100); hlt(); tick();
      ext_irq = 1; tick(); ext_irq = 0; ev(); tick();
      irq_ret = 1; tick(); irq_ret = 0; tick(); run();
      // same-cycle cause set and read clear (R11)
      wr_ctrl(4'b0010);
      reg_addr = 1; reg_rd = 1; dbg_evt = 1; tick(); reg_rd = 0; dbg_evt = 0;
      rd(1, "R11"); run();
      // privilege suppress combinations (R10)
      for (int i = 0; i < 8; i++) begin
         {jtag_insn, insn_priv, user_mode} = 3'(i);
         #1;
         chk(priv_suppress == (i == 7), "R10", "priv_suppress", int'(priv_suppress), int'(i == 7));
      end
      {jtag_insn, insn_priv, user_mode} = 3'b0;
      wr_ctrl(4'b0000); tick();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule